// File: doc/BRIEF.md
# ChaCha Double-Round Permutation Core

This block scrambles a 512-bit state of sixteen 32-bit words with the add-rotate-xor permutation used by the ChaCha stream cipher family. A caller presents the state, an even round count and a feed-forward choice, then pulses `start`. The core captures the state and performs one full double round per clock. A double round is four column quarter rounds followed by four diagonal quarter rounds. When the count runs out, the result appears on `result` and `done` pulses for one cycle.

With feed-forward on, the captured input is added word by word to the permuted state. That sum is the keystream block. With feed-forward off, the raw permuted state is returned, which is what a key-derivation step needs. Building the state (key, counter, nonce) and XORing the result with data are left to the surrounding logic.

A round count of zero, or any odd count, is refused. The core stays idle, raises `errFlag` and copies the input state straight to `result`.

Top module: `cc_permute_core`

## Requirements
- R1: Word i of the state (i = 0..15) sits at bits [32*i+31 : 32*i] of `stateIn` and `result`. Words 0-3 form row 0, 4-7 row 1, 8-11 row 2 and 12-15 row 3.
- R2: A quarter round on words (a,b,c,d) runs these steps in sequence: a=a+b, d=rotl(d^a,16), c=c+d, b=rotl(b^c,12), a=a+b, d=rotl(d^a,8), c=c+d, b=rotl(b^c,7). All sums are modulo 2^32.
- R3: The column half of a double round applies the quarter round to word groups (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15).
- R4: The diagonal half then applies it to (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14).
- R5: Suppose `start` is sampled high while idle, with a nonzero even `roundCount` of N. Then `busy` is high from the next cycle, and `done` goes high exactly N/2 clock edges after the start edge, in the same cycle that `busy` falls.
- R6: With `feedFwd` high at start, each result word is the permuted word plus the matching input word, modulo 2^32. Twenty rounds on the standard test state therefore give the standard keystream block, whose word 0 is 0xe4e7f110 and word 15 is 0x4e3c50a2.
- R7: With `feedFwd` low at start, `result` is the permuted state alone.
- R8: A start with `roundCount` zero or odd leaves the core idle. It sets `errFlag` on the next cycle, copies `stateIn` to `result` and never raises `done`. `errFlag` clears on the next accepted start.
- R9: `start` has no effect while `busy` is high. The running job's result is unaffected, and `busy` stays high until that job's `done`.
- R10: `done` is high for one cycle only. `result` holds its value until the next completion or refused start.
- R11: After reset `busy`, `done` and `errFlag` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, sampled when idle |
| stateIn | input | 512 | Input state, word i at bits 32*i upward |
| roundCount | input | ROUND_W (8) | Number of single rounds; must be even and nonzero |
| feedFwd | input | 1 | Add input state to the permuted state at the end |
| busy | output | 1 | Permutation in progress |
| done | output | 1 | One-cycle pulse; `result` valid |
| errFlag | output | 1 | Last start request was refused |
| result | output | 512 | Output state |

## Verification
On every cycle the assertions check the handshake. They cover the single-cycle `done` that closes a busy period, the acceptance and refusal of start requests, `result` changing only at a completion or a refusal, and `start` being ignored during a run. The arithmetic cannot be seen at the handshake. The quarter-round order, the column and diagonal groupings, the feed-forward sum and the exact N/2-cycle latency are shown only by the bench scenarios, which compare the output against an independent model and against the published 20-round keystream words.

// File: rtl/cc_permute_pkg.sv
package cc_permute_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 16;
  localparam int ROW_LEN   = 4;
  localparam int STATE_W   = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0]                word_t;
  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] state_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture input state
    logic step;    // advance one double round
    logic finish;  // write result
    logic reject;  // copy input to result on refused start
  } ctrl_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic quad_t quarterRound(input quad_t q);
    quad_t r;
    r = q;
    r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 16);
    r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 12);
    r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 8);
    r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 7);
    return r;
  endfunction

endpackage

// File: rtl/cc_permute_ctrl.sv
module cc_permute_ctrl
  import cc_permute_pkg::*;
#(
  parameter int ROUND_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ROUND_W-1:0] roundCount,
  output ctrl_t              ctrl,
  output logic               busy,
  output logic               done,
  output logic               errFlag
);

  localparam logic [ROUND_W-1:0] ROUNDS_PER_STEP = ROUND_W'(2);

  typedef enum logic {PH_IDLE, PH_RUN} phase_e;

  phase_e             phase;
  logic [ROUND_W-1:0] remain;
  logic               countBad;
  logic               lastStep;

  assign countBad = roundCount[0] || (roundCount == '0);
  assign lastStep = (remain == ROUNDS_PER_STEP);
  assign busy     = (phase == PH_RUN);

  always_comb begin
    ctrl        = '0;
    ctrl.load   = (phase == PH_IDLE) && start && !countBad;
    ctrl.reject = (phase == PH_IDLE) && start && countBad;
    ctrl.step   = (phase == PH_RUN);
    ctrl.finish = (phase == PH_RUN) && lastStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      remain  <= '0;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.reject) errFlag <= 1'b1;
      if (ctrl.load) begin
        phase   <= PH_RUN;
        remain  <= roundCount;
        errFlag <= 1'b0;
      end else if (ctrl.step) begin
        remain <= remain - ROUNDS_PER_STEP;
        if (lastStep) phase <= PH_IDLE;
      end
    end
  end

endmodule

// File: rtl/cc_permute_datapath.sv
module cc_permute_datapath
  import cc_permute_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  ctrl_t  ctrl,
  input  state_t stateIn,
  input  logic   feedFwd,
  output state_t result
);

  state_t work;
  state_t orig;
  logic   ffwdQ;
  state_t colSt;
  state_t diagSt;
  state_t sumSt;

  // column half: group g takes words g, g+4, g+8, g+12
  for (genvar g = 0; g < ROW_LEN; g++) begin : gCol
    quad_t qIn, qOut;
    assign qIn  = {work[g], work[g+4], work[g+8], work[g+12]};
    assign qOut = quarterRound(qIn);
    assign colSt[g]    = qOut.a;
    assign colSt[g+4]  = qOut.b;
    assign colSt[g+8]  = qOut.c;
    assign colSt[g+12] = qOut.d;
  end

  // diagonal half: each lower row is offset by one more column
  for (genvar g = 0; g < ROW_LEN; g++) begin : gDiag
    localparam int IB = ROW_LEN     + ((g + 1) % ROW_LEN);
    localparam int IC = 2 * ROW_LEN + ((g + 2) % ROW_LEN);
    localparam int ID = 3 * ROW_LEN + ((g + 3) % ROW_LEN);
    quad_t qIn, qOut;
    assign qIn  = {colSt[g], colSt[IB], colSt[IC], colSt[ID]};
    assign qOut = quarterRound(qIn);
    assign diagSt[g]  = qOut.a;
    assign diagSt[IB] = qOut.b;
    assign diagSt[IC] = qOut.c;
    assign diagSt[ID] = qOut.d;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gSum
    assign sumSt[w] = diagSt[w] + orig[w];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work   <= '0;
      orig   <= '0;
      ffwdQ  <= 1'b0;
      result <= '0;
    end else begin
      if (ctrl.load) begin
        work  <= stateIn;
        orig  <= stateIn;
        ffwdQ <= feedFwd;
      end else if (ctrl.step) begin
        work <= diagSt;
      end
      if (ctrl.finish)      result <= ffwdQ ? sumSt : diagSt;
      else if (ctrl.reject) result <= stateIn;
    end
  end

endmodule

// File: rtl/cc_permute_core.sv
module cc_permute_core
  import cc_permute_pkg::*;
#(
  parameter int ROUND_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [511:0]       stateIn,
  input  logic [ROUND_W-1:0] roundCount,
  input  logic               feedFwd,
  output logic               busy,
  output logic               done,
  output logic               errFlag,
  output logic [511:0]       result
);

  ctrl_t  ctrl;
  state_t resultSt;

  cc_permute_ctrl #(.ROUND_W(ROUND_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .roundCount (roundCount),
    .ctrl       (ctrl),
    .busy       (busy),
    .done       (done),
    .errFlag    (errFlag)
  );

  cc_permute_datapath uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .stateIn (state_t'(stateIn)),
    .feedFwd (feedFwd),
    .result  (resultSt)
  );

  assign result = resultSt;

endmodule

// File: rtl/cc_permute_chk.sv
module cc_permute_chk #(
  parameter int ROUND_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [511:0]       stateIn,
  input logic [ROUND_W-1:0] roundCount,
  input logic               busy,
  input logic               done,
  input logic               errFlag,
  input logic [511:0]       result
);

  logic badCount;
  assign badCount = roundCount[0] || (roundCount == '0);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !badCount) |=> (busy && !errFlag));

  // R8
  refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && badCount) |=> (errFlag && !busy && !done && result == $past(stateIn)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> (done || errFlag));

endmodule

bind cc_permute_core cc_permute_chk #(.ROUND_W(ROUND_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .stateIn    (stateIn),
  .roundCount (roundCount),
  .busy       (busy),
  .done       (done),
  .errFlag    (errFlag),
  .result     (result)
);

// File: tb/tb_cc_permute_core.sv
module tb_cc_permute_core;

  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [511:0]  stateIn = '0;
  logic [RW-1:0] roundCount = '0;
  logic          feedFwd = 1'b0;
  logic          busy, done, errFlag;
  logic [511:0]  result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cc_permute_core #(.ROUND_W(RW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .stateIn(stateIn),
    .roundCount(roundCount), .feedFwd(feedFwd),
    .busy(busy), .done(done), .errFlag(errFlag), .result(result)
  );

  // ---------------- reference model ----------------
  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [511:0] qrAt(input logic [511:0] s, input int ia, ib, ic, id);
    logic [31:0] a, b, c, d;
    logic [511:0] o;
    a = s[32*ia +: 32]; b = s[32*ib +: 32]; c = s[32*ic +: 32]; d = s[32*id +: 32];
    a = a + b; d = rl(d ^ a, 16);
    c = c + d; b = rl(b ^ c, 12);
    a = a + b; d = rl(d ^ a, 8);
    c = c + d; b = rl(b ^ c, 7);
    o = s;
    o[32*ia +: 32] = a; o[32*ib +: 32] = b; o[32*ic +: 32] = c; o[32*id +: 32] = d;
    return o;
  endfunction

  function automatic logic [511:0] model(input logic [511:0] s, input int rounds, input bit ff);
    logic [511:0] x;
    x = s;
    for (int r = 0; r < rounds / 2; r++) begin
      x = qrAt(x, 0, 4, 8, 12);  x = qrAt(x, 1, 5, 9, 13);
      x = qrAt(x, 2, 6, 10, 14); x = qrAt(x, 3, 7, 11, 15);
      x = qrAt(x, 0, 5, 10, 15); x = qrAt(x, 1, 6, 11, 12);
      x = qrAt(x, 2, 7, 8, 13);  x = qrAt(x, 3, 4, 9, 14);
    end
    if (ff) for (int w = 0; w < 16; w++) x[32*w +: 32] = x[32*w +: 32] + s[32*w +: 32];
    return x;
  endfunction

  function automatic logic [511:0] mixState(input logic [31:0] seed);
    logic [511:0] s;
    logic [31:0] v;
    v = seed;
    for (int w = 0; w < 16; w++) begin
      v = v * 32'd1664525 + 32'd1013904223;
      s[32*w +: 32] = v;
    end
    return s;
  endfunction

  // ---------------- check helpers ----------------
  task automatic checkVal(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finishRun();
    end
  end

  // drive a start for one cycle; returns at the negedge after the start edge
  task automatic pulseStart(input logic [511:0] s, input int rounds, input bit ff);
    @(negedge clk);
    start = 1'b1; stateIn = s; roundCount = RW'(rounds); feedFwd = ff;
    @(negedge clk);
    start = 1'b0;
  endtask

  // counts negedges after the start edge until done; first one counts 1
  task automatic waitDone(output int k);
    k = 1;
    while (!done && k < 300) begin
      @(negedge clk);
      k++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    checkVal("R11 busy", 512'(busy), 512'(0));
    checkVal("R11 done", 512'(done), 512'(0));
    checkVal("R11 errFlag", 512'(errFlag), 512'(0));
    checkVal("R11 result", result, '0);
  endtask

  task automatic testKnownBlock();
    logic [511:0] s;
    int k;
    s = '0;
    s[32*0 +: 32] = 32'h61707865; s[32*1 +: 32] = 32'h3320646e;
    s[32*2 +: 32] = 32'h79622d32; s[32*3 +: 32] = 32'h6b206574;
    for (int w = 0; w < 8; w++)
      s[32*(4+w) +: 32] = {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
    s[32*12 +: 32] = 32'h00000001; s[32*13 +: 32] = 32'h09000000;
    s[32*14 +: 32] = 32'h4a000000; s[32*15 +: 32] = 32'h00000000;
    pulseStart(s, 20, 1'b1);
    checkVal("R5 busy after start", 512'(busy), 512'(1));
    waitDone(k);
    checkVal("R5 latency 20 rounds", 512'(k), 512'(11));
    checkVal("R5 busy low at done", 512'(busy), 512'(0));
    checkVal("R6 keystream word0", 512'(result[31:0]), 512'(32'he4e7f110));
    checkVal("R6 keystream word15", 512'(result[511:480]), 512'(32'h4e3c50a2));
    checkVal("R1 R2 R3 R4 R6 full block", result, model(s, 20, 1'b1));
    @(negedge clk);
    checkVal("R10 done one cycle", 512'(done), 512'(0));
    checkVal("R10 result held", result, model(s, 20, 1'b1));
  endtask

  task automatic testNoFeedForward();
    logic [511:0] s;
    int k;
    s = mixState(32'h1234abcd);
    pulseStart(s, 8, 1'b0);
    waitDone(k);
    checkVal("R5 latency 8 rounds", 512'(k), 512'(5));
    checkVal("R7 raw permutation 8 rounds", result, model(s, 8, 1'b0));
  endtask

  task automatic testMinRounds();
    logic [511:0] s;
    int k;
    s = mixState(32'h0badf00d);
    pulseStart(s, 2, 1'b1);
    waitDone(k);
    checkVal("R5 latency 2 rounds", 512'(k), 512'(2));
    checkVal("R3 R4 R6 single double round", result, model(s, 2, 1'b1));
  endtask

  task automatic testMaxRounds();
    logic [511:0] s;
    int k;
    s = mixState(32'h5a5a0001);
    pulseStart(s, 254, 1'b0);
    waitDone(k);
    checkVal("R5 latency 254 rounds", 512'(k), 512'(128));
    checkVal("R7 254 rounds", result, model(s, 254, 1'b0));
  endtask

  task automatic testRefused(input int rounds, input logic [31:0] seed);
    logic [511:0] s;
    bit sawDone;
    s = mixState(seed);
    pulseStart(s, rounds, 1'b1);
    checkVal("R8 errFlag set", 512'(errFlag), 512'(1));
    checkVal("R8 stays idle", 512'(busy), 512'(0));
    checkVal("R8 input passed through", result, s);
    sawDone = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (done) sawDone = 1'b1;
      @(negedge clk);
    end
    checkVal("R8 no done", 512'(sawDone), 512'(0));
  endtask

  task automatic testErrClear();
    logic [511:0] s;
    int k;
    s = mixState(32'h77777777);
    pulseStart(s, 4, 1'b1);
    checkVal("R8 errFlag cleared by accepted start", 512'(errFlag), 512'(0));
    waitDone(k);
    checkVal("R6 after error", result, model(s, 4, 1'b1));
  endtask

  task automatic testStartWhileBusy();
    logic [511:0] a, b;
    int k;
    a = mixState(32'hcafe0001);
    b = mixState(32'hdead0002);
    pulseStart(a, 12, 1'b1);
    @(negedge clk);
    start = 1'b1; stateIn = b; roundCount = RW'(2); feedFwd = 1'b0;
    @(negedge clk);
    start = 1'b0;
    checkVal("R9 still busy", 512'(busy), 512'(1));
    k = 3;
    while (!done && k < 300) begin
      @(negedge clk);
      k++;
    end
    checkVal("R9 latency unchanged", 512'(k), 512'(7));
    checkVal("R9 result of first job", result, model(a, 12, 1'b1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testKnownBlock();
    testNoFeedForward();
    testMinRounds();
    testRefused(7, 32'h13579bdf);
    testRefused(0, 32'h2468ace0);
    testErrClear();
    testStartWhileBusy();
    testMaxRounds();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule